// File: doc/BRIEF.md
# CSR Instruction Execute Unit

This block carries out the six control-and-status-register instructions (swap, set-bits and clear-bits, each with a register source and a 5-bit immediate source) against a small local CSR file. It takes an instruction word, the value of the source register and the hart's current privilege level. In the same cycle it returns the value bound for the destination register, a writeback enable and an illegal-instruction flag. Any CSR update takes effect at the next rising clock edge.

Two pulse outputs show when a CSR is read and when it is written, so read and write side effects can be tied to them. Whether a read or a write happens depends on the instruction kind and on whether the destination index, the source index or the immediate is zero. The local file has four registers:

- a user-level scratch register at 0x040
- a machine-level scratch register at 0x340
- a machine-level exception-PC register at 0x341, whose two low bits always read zero
- a read-only machine-level identification register at 0xF11

Top module: `csrx_unit`

## Requirements
- R1: An instruction is handled only when insn_i[6:0] is 7'b1110011 and insn_i[14:12] is 001 (swap), 010 (set), 011 (clear), 101 (swap-immediate), 110 (set-immediate) or 111 (clear-immediate). Any other word leaves all five outputs low or zero and changes no CSR.
- R2: A swap returns the old CSR value, zero-extended to XLEN, and the CSR takes the operand at the next edge. The address is insn_i[31:20], the source field is insn_i[19:15] and the destination index is insn_i[11:7].
- R3: A swap whose destination index is 0 keeps csr_rd_stb_o low, still writes the CSR and still pulses csr_wr_stb_o.
- R4: A register-form swap whose source field is 0 writes zero into the CSR, whatever the value on rs1_val_i.
- R5: Set writes old OR operand, and clear writes old AND NOT operand. Both return the old value.
- R6: A set or clear whose source field is 0, in either form, reads the CSR into the result, keeps csr_wr_stb_o low and leaves the CSR unchanged.
- R7: Immediate forms use the 5-bit source field, zero-extended, as the operand. rs1_val_i is ignored.
- R8: An address outside the four implemented ones raises illegal_o with no strobe, no writeback and no CSR change.
- R9: If address bits 9:8, read as an unsigned level, exceed priv_i (0 user, 1 supervisor, 3 machine), the instruction raises illegal_o with no effect.
- R10: An address with bits 11:10 equal to 11 is read-only. An instruction that would write it raises illegal_o with no effect. A read-only access that writes nothing returns the register value (ID_VALUE at 0xF11).
- R11: rd_we_o is high only for a legal handled instruction with a nonzero destination index. rd_data_o is zero whenever rd_we_o is low.
- R12: Bits 1:0 of the exception-PC register always read zero, whatever value was written.
- R13: With insn_valid_i low, all outputs stay low or zero and no CSR changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all writable CSRs |
| insn_valid_i | input | 1 | The instruction word is to be executed this cycle |
| insn_i | input | 32 | Instruction word |
| rs1_val_i | input | XLEN | Value of the source register |
| priv_i | input | 2 | Current privilege level |
| rd_data_o | output | XLEN | Result for the destination register |
| rd_we_o | output | 1 | Destination register writeback enable |
| illegal_o | output | 1 | Illegal-instruction flag |
| csr_rd_stb_o | output | 1 | A CSR read (with its side effects) happens this cycle |
| csr_wr_stb_o | output | 1 | A CSR write happens at the coming edge |

## Verification
The in-line properties check on every cycle that an illegal instruction raises no strobe and no writeback, that a swap to index 0 raises no read strobe, and that a set or clear with a zero source raises no write strobe. They also check that writeback never targets index 0 and that a write to the machine scratch register lands on the next edge. The actual values written (OR, AND NOT, zero-extended immediates, forced zero for a register source of x0, the cleared low bits of the exception PC) and the privilege and read-only decisions can only be shown by the bench's sweep. That sweep covers every funct3, address, privilege and zero/nonzero operand combination, and checks each result against a CSR model kept in the bench.

// File: rtl/csrx_pkg.sv
package csrx_pkg;

    localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

    localparam int F3_LSB  = 12;
    localparam int RD_LSB  = 7;
    localparam int SRC_LSB = 15;
    localparam int ADR_LSB = 20;

    localparam logic [11:0] ADR_USCRATCH = 12'h040;
    localparam logic [11:0] ADR_MSCRATCH = 12'h340;
    localparam logic [11:0] ADR_MEXCPC   = 12'h341;
    localparam logic [11:0] ADR_IDENT    = 12'hF11;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_SWAP = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef struct packed {
        logic        hit;
        csr_op_e     op;
        logic        use_imm;
        logic [11:0] addr;
        logic [4:0]  rd;
        logic [4:0]  src;
    } csr_dec_t;

    function automatic logic addr_is_read_only(input logic [11:0] a);
        return a[11:10] == 2'b11;
    endfunction

    function automatic logic [1:0] addr_min_priv(input logic [11:0] a);
        return a[9:8];
    endfunction

endpackage

// File: rtl/csrx_decode.sv
module csrx_decode
    import csrx_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] insn_i,
    output csr_dec_t    dec_o,
    output logic        do_read_o,
    output logic        do_write_o
);
    logic [2:0] f3;
    csr_op_e    op;

    assign f3 = insn_i[F3_LSB +: 3];

    always_comb begin
        op = OP_NONE;
        if (valid_i && insn_i[6:0] == OPC_SYSTEM) begin
            unique case (f3[1:0])
                2'b01:   op = OP_SWAP;
                2'b10:   op = OP_SET;
                2'b11:   op = OP_CLR;
                default: op = OP_NONE;
            endcase
        end
    end

    always_comb begin
        dec_o.hit     = (op != OP_NONE);
        dec_o.op      = op;
        dec_o.use_imm = f3[2];
        dec_o.addr    = insn_i[ADR_LSB +: 12];
        dec_o.rd      = insn_i[RD_LSB +: 5];
        dec_o.src     = insn_i[SRC_LSB +: 5];
    end

    // Swap reads only for a real destination; set/clear write only for a nonzero source.
    always_comb begin
        do_read_o  = 1'b0;
        do_write_o = 1'b0;
        if (dec_o.hit) begin
            if (op == OP_SWAP) begin
                do_read_o  = (dec_o.rd != 5'd0);
                do_write_o = 1'b1;
            end else begin
                do_read_o  = 1'b1;
                do_write_o = (dec_o.src != 5'd0);
            end
        end
    end
endmodule

// File: rtl/csrx_alu.sv
module csrx_alu
    import csrx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  csr_op_e             op_i,
    input  logic                use_imm_i,
    input  logic [4:0]          src_i,
    input  logic [XLEN-1:0]     rs1_val_i,
    input  logic [XLEN-1:0]     old_i,
    output logic [XLEN-1:0]     new_o
);
    logic [XLEN-1:0] operand;

    always_comb begin
        if (use_imm_i)
            operand = {{(XLEN-5){1'b0}}, src_i};
        else if (src_i == 5'd0)
            operand = '0;
        else
            operand = rs1_val_i;
    end

    always_comb begin
        unique case (op_i)
            OP_SWAP: new_o = operand;
            OP_SET:  new_o = old_i | operand;
            OP_CLR:  new_o = old_i & ~operand;
            default: new_o = old_i;
        endcase
    end
endmodule

// File: rtl/csrx_regfile.sv
module csrx_regfile
    import csrx_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] ID_VALUE  = 32'h5A00_0001,
    parameter int              PC_ALIGN  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     addr_i,
    input  logic            wr_en_i,
    input  logic [XLEN-1:0] wr_data_i,
    output logic [XLEN-1:0] rdata_o,
    output logic            present_o
);
    localparam logic [XLEN-1:0] PC_MASK = ~((XLEN)'((1 << PC_ALIGN) - 1));

    logic [XLEN-1:0] uscr_q, mscr_q, mepc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            uscr_q <= '0;
            mscr_q <= '0;
            mepc_q <= '0;
        end else if (wr_en_i) begin
            unique case (addr_i)
                ADR_USCRATCH: uscr_q <= wr_data_i;
                ADR_MSCRATCH: mscr_q <= wr_data_i;
                ADR_MEXCPC:   mepc_q <= wr_data_i & PC_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        present_o = 1'b1;
        rdata_o   = '0;
        unique case (addr_i)
            ADR_USCRATCH: rdata_o = uscr_q;
            ADR_MSCRATCH: rdata_o = mscr_q;
            ADR_MEXCPC:   rdata_o = mepc_q;
            ADR_IDENT:    rdata_o = ID_VALUE;
            default:      present_o = 1'b0;
        endcase
    end

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == ADR_MSCRATCH) |=> (mscr_q == $past(wr_data_i)))
        else $error("machine scratch write did not land");
endmodule

// File: rtl/csrx_unit.sv
module csrx_unit
    import csrx_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] ID_VALUE = 32'h5A00_0001
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_valid_i,
    input  logic [31:0]     insn_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [1:0]      priv_i,
    output logic [XLEN-1:0] rd_data_o,
    output logic            rd_we_o,
    output logic            illegal_o,
    output logic            csr_rd_stb_o,
    output logic            csr_wr_stb_o
);
    csr_dec_t        dec;
    logic            do_read, do_write, present, legal;
    logic [XLEN-1:0] old_val, new_val;

    csrx_decode u_dec (
        .valid_i    (insn_valid_i),
        .insn_i     (insn_i),
        .dec_o      (dec),
        .do_read_o  (do_read),
        .do_write_o (do_write)
    );

    csrx_alu #(.XLEN(XLEN)) u_alu (
        .op_i      (dec.op),
        .use_imm_i (dec.use_imm),
        .src_i     (dec.src),
        .rs1_val_i (rs1_val_i),
        .old_i     (old_val),
        .new_o     (new_val)
    );

    csrx_regfile #(.XLEN(XLEN), .ID_VALUE(ID_VALUE)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (dec.addr),
        .wr_en_i   (csr_wr_stb_o),
        .wr_data_i (new_val),
        .rdata_o   (old_val),
        .present_o (present)
    );

    always_comb begin
        illegal_o = dec.hit && (!present
                              || (priv_i < addr_min_priv(dec.addr))
                              || (do_write && addr_is_read_only(dec.addr)));
        legal        = dec.hit && !illegal_o;
        csr_rd_stb_o = legal && do_read;
        csr_wr_stb_o = legal && do_write;
        rd_we_o      = legal && (dec.rd != 5'd0);
        rd_data_o    = rd_we_o ? old_val : '0;
    end

    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!csr_rd_stb_o && !csr_wr_stb_o && !rd_we_o))
        else $error("illegal instruction had an effect");

    p_swap_rd0_noread_r3: assert property (@(posedge clk) disable iff (rst)
        (dec.hit && dec.op == OP_SWAP && dec.rd == 5'd0) |-> !csr_rd_stb_o)
        else $error("swap to x0 read the CSR");

    p_setclr_zero_nowrite_r6: assert property (@(posedge clk) disable iff (rst)
        (dec.hit && dec.op != OP_SWAP && dec.src == 5'd0) |-> !csr_wr_stb_o)
        else $error("set/clear with zero source wrote the CSR");

    p_wb_nonzero_rd_r11: assert property (@(posedge clk) disable iff (rst)
        rd_we_o |-> (insn_i[11:7] != 5'd0 && insn_valid_i))
        else $error("writeback to x0 or without valid");

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !insn_valid_i |-> (!csr_rd_stb_o && !csr_wr_stb_o && !illegal_o && !rd_we_o))
        else $error("activity without valid");
endmodule

// File: tb/csrx_unit_tb_top.sv
`timescale 1ns/1ps
module csrx_unit_tb_top;
    localparam logic [31:0] IDV = 32'h5A00_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] rs1v = '0;
    logic [1:0]  priv = 2'd0;
    logic [31:0] rd_data;
    logic        rd_we, illegal, rd_stb, wr_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_uscr = '0, m_mscr = '0, m_mepc = '0;

    always #2.5 clk = ~clk;

    csrx_unit dut_i (
        .clk(clk), .rst(rst), .insn_valid_i(valid), .insn_i(insn),
        .rs1_val_i(rs1v), .priv_i(priv), .rd_data_o(rd_data), .rd_we_o(rd_we),
        .illegal_o(illegal), .csr_rd_stb_o(rd_stb), .csr_wr_stb_o(wr_stb)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_get(input logic [11:0] a);
        case (a)
            12'h040: return m_uscr;
            12'h340: return m_mscr;
            12'h341: return m_mepc;
            12'hF11: return IDV;
            default: return 32'h0;
        endcase
    endfunction

    task automatic run(input logic v, input logic [6:0] opc, input logic [2:0] f3,
                       input logic [11:0] a, input logic [1:0] p, input logic [4:0] rd,
                       input logic [4:0] src, input logic [31:0] rv);
        logic handled, imm, impl, ro, lowp, rdo, wro, ill, ewe, erd, ewr;
        logic [31:0] old, opnd, nv;
        string tag;
        handled = v && opc == 7'h73 && f3[1:0] != 2'b00;
        imm  = f3[2];
        impl = (a == 12'h040 || a == 12'h340 || a == 12'h341 || a == 12'hF11);
        ro   = (a[11:10] == 2'b11);
        lowp = (p < a[9:8]);
        rdo  = (f3[1:0] == 2'b01) ? (rd != 0) : 1'b1;
        wro  = (f3[1:0] == 2'b01) ? 1'b1 : (src != 0);
        ill  = handled && (!impl || lowp || (wro && ro));
        erd  = handled && !ill && rdo;
        ewr  = handled && !ill && wro;
        ewe  = handled && !ill && rd != 0;
        old  = m_get(a);
        opnd = imm ? {27'd0, src} : (src == 0 ? 32'd0 : rv);
        case (f3[1:0])
            2'b01:   nv = opnd;
            2'b10:   nv = old | opnd;
            default: nv = old & ~opnd;
        endcase
        if (!v) tag = "R13";
        else if (!handled) tag = "R1";
        else if (!impl) tag = "R8";
        else if (lowp) tag = "R9";
        else if (ro) tag = "R10";
        else if (a == 12'h341 && wro) tag = "R12";
        else if (f3[1:0] == 2'b01 && rd == 0) tag = "R3";
        else if (f3[1:0] == 2'b01 && !imm && src == 0) tag = "R4";
        else if (imm && wro) tag = "R7";
        else if (f3[1:0] == 2'b01) tag = "R2";
        else if (src == 0) tag = "R6";
        else tag = "R5";

        valid = v; insn = {a, src, f3, rd, opc}; rs1v = rv; priv = p;
        #2;
        chk(tag, "illegal", {31'd0, illegal}, {31'd0, ill});
        chk(tag, "rd_stb", {31'd0, rd_stb}, {31'd0, erd});
        chk(tag, "wr_stb", {31'd0, wr_stb}, {31'd0, ewr});
        chk("R11", "rd_we", {31'd0, rd_we}, {31'd0, ewe});
        chk(tag, "rd_data", rd_data, ewe ? old : 32'd0);
        @(posedge clk);
        #1;
        if (ewr) begin
            case (a)
                12'h040: m_uscr = nv;
                12'h340: m_mscr = nv;
                12'h341: m_mepc = nv & ~32'h3;
                default: ;
            endcase
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] addrs [5];
        logic [1:0]  privs [3];
        int n;
        addrs = '{12'h040, 12'h340, 12'h341, 12'hF11, 12'h342};
        privs = '{2'd0, 2'd1, 2'd3};
        n = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // Reset state: outputs quiet while idle (R13)
        chk("R13", "reset rd_we", {31'd0, rd_we}, 32'd0);
        chk("R13", "reset rd_data", rd_data, 32'd0);
        rst = 1'b0;
        @(posedge clk);
        #1;
        // Reset values of writable CSRs read back as zero (R2)
        run(1, 7'h73, 3'b010, 12'h040, 2'd3, 5'd5, 5'd0, 32'd0);
        run(1, 7'h73, 3'b010, 12'h340, 2'd3, 5'd5, 5'd0, 32'd0);
        run(1, 7'h73, 3'b010, 12'h341, 2'd3, 5'd5, 5'd0, 32'd0);
        // Non-system opcode ignored (R1)
        run(1, 7'h13, 3'b001, 12'h340, 2'd3, 5'd5, 5'd7, 32'hFFFF_FFFF);
        run(1, 7'h33, 3'b010, 12'h040, 2'd3, 5'd5, 5'd7, 32'hFFFF_FFFF);
        for (int vv = 1; vv >= 0; vv--)
            for (int f = 0; f < 8; f++)
                for (int ai = 0; ai < 5; ai++)
                    for (int pi = 0; pi < 3; pi++)
                        for (int r = 0; r < 2; r++)
                            for (int s = 0; s < 2; s++)
                                for (int k = 0; k < 2; k++) begin
                                    n++;
                                    run(vv[0], 7'h73, f[2:0], addrs[ai], privs[pi],
                                        r ? 5'd5 : 5'd0, s ? 5'd7 : 5'd0,
                                        k ? 32'hA5A5_0F0F : (32'h0000_FFF3 ^ n));
                                end
        // Final read-back of every CSR (R2, R10, R12)
        run(1, 7'h73, 3'b010, 12'h040, 2'd3, 5'd6, 5'd0, 32'd0);
        run(1, 7'h73, 3'b010, 12'h340, 2'd3, 5'd6, 5'd0, 32'd0);
        run(1, 7'h73, 3'b010, 12'h341, 2'd3, 5'd6, 5'd0, 32'd0);
        run(1, 7'h73, 3'b010, 12'hF11, 2'd3, 5'd6, 5'd0, 32'd0);
        valid = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule